// File: doc/BRIEF.md
# Masked Byte Search Unit

This execution unit looks for a character inside a 64-bit word. It treats the word as eight byte lanes, each holding one character. The caller supplies a pattern byte and a bit mask. Only the bits that are set in the mask take part in the comparison, so a single search can match a whole class of characters. Two examples are any letter regardless of case, or any byte with a given high nibble.

The unit reports two results:

- whether any lane matched;
- the position of the lowest-numbered matching lane.

A search is started with a one-cycle `start` request. It completes with a one-cycle `done` pulse, and both results stay valid until the next search completes.

Internally a small state machine steps through three named states:

- **IDLE**: waiting for `start`.
- **EVAL**: the per-lane compare results have been registered.
- **EMIT**: the priority-encoded position has been registered and `done` is raised.

The transitions are:

- **accept** (IDLE to EVAL): taken when `start` is high.
- **encode** (EVAL to EMIT): always taken.
- **release** (EMIT to IDLE): always taken.
- **hold** (IDLE to IDLE): taken when there is no request.

Top module: `byte_scan_unit`

## Requirements
- R1: After reset, `busy`, `done`, `found` and `index` are all 0.
- R2: Lane i matches when `((data[8i+7:8i] ^ pattern) & mask) == 0`. Bits with a mask bit of 0 are not compared.
- R3: Lane 0 is `data[7:0]`. When several lanes match, `index` reports the smallest matching lane number, and `found` is 1.
- R4: When no lane matches, `found` is 0 and `index` is 0.
- R5: When `mask` is all zeros, every lane matches, so `found` is 1 and `index` is 0.
- R6: Let the rising edge at which `start` is sampled in IDLE be the first edge. `done` is then high for exactly one cycle, beginning after the second rising edge that follows.
- R7: `busy` is high from the accepting edge until `done` falls. A `start` seen while `busy` is high is ignored, and the result reflects the operands of the accepted request.
- R8: `found` and `index` keep their values from one completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Search request, sampled only in IDLE |
| pattern | input | 8 | Byte to look for |
| mask | input | 8 | Bits of the byte that must match |
| data | input | 64 | Word to search, lane 0 in bits 7:0 |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | At least one lane matched |
| index | output | 3 | Lowest matching lane |

## Verification
A positional sweep places a single target character in each lane in turn, with the other lanes filled with non-matching bytes. This separates a correct lane order from a reversed or off-by-one encode. A second pattern plants two matches and tests that the lower lane wins. Masks that drop single bits, all bits, or none check that each bit is compared only where it is enabled. A long pseudo-random run covers mixed multi-match and no-match words. A request presented during EVAL checks that a busy unit ignores new operands.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_EMIT = 2'd2
    } scan_state_t;
endpackage

// File: rtl/lane_compare.sv
module lane_compare #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0]       pattern,
    input  logic [LANE_W-1:0]       mask,
    input  logic [LANES*LANE_W-1:0] data,
    output logic [LANES-1:0]        hit
);
    // One masked comparator per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] diff;
        assign diff   = (data[g*LANE_W +: LANE_W] ^ pattern) & mask;
        assign hit[g] = (diff == '0);
    end
endmodule

// File: rtl/first_hit_encoder.sv
module first_hit_encoder #(
    parameter int LANES = 8,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] hits,
    output logic             any,
    output logic [IDX_W-1:0] pos
);
    always_comb begin
        any = |hits;
        pos = '0;
        // Walk from the top lane down, so the lowest hit is written last and wins.
        for (int i = LANES - 1; i >= 0; i--) begin
            if (hits[i]) pos = IDX_W'(i);
        end
    end
endmodule

// File: rtl/byte_scan_unit.sv
module byte_scan_unit
    import bscan_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int IDX_W  = $clog2(LANES),
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANE_W-1:0] pattern,
    input  logic [LANE_W-1:0] mask,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [IDX_W-1:0]  index
);
    scan_state_t       state_q, state_d;
    logic [LANES-1:0]  hit_now, hits_q;
    logic              enc_any;
    logic [IDX_W-1:0]  enc_pos;

    lane_compare #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
        .pattern(pattern), .mask(mask), .data(data), .hit(hit_now)
    );

    first_hit_encoder #(.LANES(LANES), .IDX_W(IDX_W)) u_enc (
        .hits(hits_q), .any(enc_any), .pos(enc_pos)
    );

    // Next-state logic for the four named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EVAL;   // accept; otherwise hold
            ST_EVAL: state_d = ST_EMIT;              // encode
            ST_EMIT: state_d = ST_IDLE;              // release
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits_q <= '0;
            found  <= 1'b0;
            index  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) hits_q <= hit_now;
            if (state_q == ST_EVAL) begin
                found <= enc_any;
                index <= enc_any ? enc_pos : '0;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_EMIT);

    // Assertions.

    // R6: done lasts exactly one cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done is preceded by a cycle that was busy and not yet done.
    p_done_after_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> done);

    // R7: the unit is busy whenever done is raised.
    p_busy_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R7: once EVAL is entered, a new start cannot restart or extend the search.
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && start) |=> (state_q == ST_EMIT));

    // R4: a completed search with no match reports index 0.
    p_nomatch_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (index == '0));

    // R8: results hold while no search is finishing.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_EVAL) |=> ($stable(found) && $stable(index)));
endmodule

// File: tb/tb_byte_scan_unit.sv
module tb_byte_scan_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  pattern = '0;
    logic [7:0]  mask = '0;
    logic [63:0] data = '0;
    logic        busy, done, found;
    logic [2:0]  index;

    int checks = 0;
    int fails  = 0;

    byte_scan_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
        .mask(mask), .data(data), .busy(busy), .done(done),
        .found(found), .index(index)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected results computed from the matching rule of R2 and R3.
    function automatic void model(input logic [7:0] p, input logic [7:0] m,
                                  input logic [63:0] d,
                                  output bit f, output int idx);
        f = 0;
        idx = 0;
        for (int i = 0; i < 8; i++) begin
            if (!f && (((d >> (8 * i)) & 64'hFF) & m) == (p & m)) begin
                f = 1;
                idx = i;
            end
        end
    endfunction

    // Runs one search and checks the busy/done sequence and the results.
    // Entered and left at a falling edge.
    task automatic search(input logic [7:0] p, input logic [7:0] m,
                          input logic [63:0] d, input string req);
        bit ef;
        int ei;
        model(p, m, d, ef, ei);
        pattern = p;
        mask = m;
        data = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R6", {busy, done}, 2);
        @(negedge clk);
        chk(done && busy, "R6", {busy, done}, 3);
        chk(found == ef, req, found, ef);
        chk(int'(index) == ei, req, index, ei);
        @(negedge clk);
        chk(!done && !busy, "R7", {busy, done}, 0);
    endtask

    logic [63:0] lfsr;
    logic [7:0]  saved_f;
    logic [2:0]  saved_i;

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !done && !found && index == 0, "R1", {busy, done, found, index}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: a single target in each lane, surrounded by non-matching bytes.
        for (int p = 0; p < 8; p++) begin
            logic [63:0] w;
            w = 64'h2E2E2E2E2E2E2E2E;
            w[8 * p +: 8] = 8'h70;
            search(8'h70, 8'hFF, w, "R3");
        end

        // R3: two matches, the lower lane must win.
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                logic [63:0] w;
                w = 64'h1111111111111111;
                w[8 * a +: 8] = 8'h41;
                w[8 * b +: 8] = 8'h41;
                search(8'h41, 8'hFF, w, "R3");
            end
        end

        // R2: dropping one mask bit lets a byte that differs only in that bit match.
        for (int k = 0; k < 8; k++) begin
            logic [63:0] w;
            w = 64'h0;
            w[8 * 5 +: 8] = 8'hA5 ^ (8'h1 << k);
            search(8'hA5, 8'hFF, w | 64'h5A5A5A5A5A, "R2");
            search(8'hA5, ~(8'h1 << k), w | 64'h5A5A5A5A5A, "R2");
        end

        // R4: no lane matches.
        search(8'hFF, 8'hFF, 64'h0011223344556677, "R4");
        search(8'h80, 8'h80, 64'h7F7F7F7F7F7F7F7F, "R4");

        // R5: an all-zero mask matches every lane.
        search(8'h00, 8'h00, 64'hDEADBEEFCAFEF00D, "R5");
        search(8'hFF, 8'h00, 64'h0, "R5");

        // R2/R3/R4: pseudo-random words, patterns and masks.
        lfsr = 64'h1234_5678_9ABC_DEF1;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            search(lfsr[7:0] ^ lfsr[23:16], lfsr[47:40] | lfsr[55:48],
                   lfsr ^ {lfsr[31:0], lfsr[63:32]}, "R2");
        end

        // R7: a start during EVAL with other operands is ignored.
        pattern = 8'h33;
        mask = 8'hFF;
        data = 64'h3300000000000000;   // match in lane 7
        start = 1'b1;
        @(negedge clk);
        pattern = 8'h00;
        data = 64'h0;                  // would match lane 0
        @(negedge clk);
        start = 1'b0;
        chk(done && found && index == 7, "R7", index, 7);
        @(negedge clk);
        chk(!busy && !done, "R7", {busy, done}, 0);
        saved_f = {7'd0, found};
        saved_i = index;

        // R8: results hold during idle cycles.
        @(negedge clk);
        @(negedge clk);
        chk(found == saved_f[0] && index == saved_i, "R8", index, saved_i);

        // R8: results hold through EVAL and change only at the next completion.
        pattern = 8'h44;
        mask = 8'hFF;
        data = 64'h0000000000004400;   // match in lane 1
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(index == 7 && found, "R8", index, 7);
        @(negedge clk);
        chk(index == 1 && found, "R8", index, 1);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule